// File: doc/BRIEF.md
# Two-Thread Banked Register File Arbiter

This block fronts a register file that is cut into several banks, each with a single read port of its own, and shared by two hardware threads. In every cycle each thread may present one read request carrying a physical register tag. The low-order bits of the tag pick the bank and the remaining bits pick the row inside it. Requests that fall into different banks are all served in the same cycle. When both threads aim at the same bank, only one of them is granted. The other thread keeps its request and its tag asserted until a later cycle grants it.

Which thread wins a conflict is set by a small policy register. In round-robin mode, each bank keeps its own pointer that names the favoured thread, and the pointer moves to the other thread after that bank settles a conflict. In fixed mode, the thread named in the register wins every conflict in every bank. Grants are combinational in the request cycle. The read data and its valid flag follow one cycle later. A single write port fills the banks, and a write becomes visible to reads from the next cycle on.

Top module: `rf_bank_arbiter`

## Requirements
- R1: The bank of a tag is its low log2(NUM_BANKS) bits (bits [1:0] by default) and the row is the rest. Two requests in one cycle to different banks are both granted in that cycle.
- R2: When both threads request the same bank in one cycle, exactly one of them is granted, and that includes the case of an identical tag.
- R3: In fixed mode (policy bit = 1), every conflict is won by the thread named by the priority bit (0 = thread 0, 1 = thread 1), cycle after cycle, with no alternation.
- R4: In round-robin mode (policy bit = 0), each bank's pointer favours thread 0 after reset. It passes to the other thread only after that bank resolves a conflict in round-robin mode. Conflicts in other banks and conflicts in fixed mode leave it alone.
- R5: A granted read raises that thread's valid output one cycle after the grant, with the word stored at the tag. A thread with no request gets no grant, and its valid output is low one cycle later.
- R6: A write to the policy register (enable, policy bit, priority bit) affects arbitration from the next cycle on, and the same cycle still uses the old setting. After reset the policy is round-robin with priority thread 0.
- R7: A word written through the write port can be read from the next cycle on. A read of the same tag in the cycle of the write returns the previous word.
- R8: A request that is denied and held with the same tag is granted in a later cycle, once it wins a conflict or no longer conflicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Policy register write enable |
| cfg_fixed | input | 1 | Policy: 0 round-robin, 1 fixed priority |
| cfg_prio | input | 1 | Thread favoured in fixed mode |
| wr_en | input | 1 | Register file write enable |
| wr_tag | input | TAG_W | Tag written |
| wr_data | input | DATA_W | Word written |
| t0_req | input | 1 | Thread 0 read request |
| t0_tag | input | TAG_W | Thread 0 read tag |
| t1_req | input | 1 | Thread 1 read request |
| t1_tag | input | TAG_W | Thread 1 read tag |
| t0_grant | output | 1 | Thread 0 granted this cycle |
| t1_grant | output | 1 | Thread 1 granted this cycle |
| t0_rvalid | output | 1 | Thread 0 read data valid |
| t0_rdata | output | DATA_W | Thread 0 read data |
| t1_rvalid | output | 1 | Thread 1 read data valid |
| t1_rdata | output | DATA_W | Thread 1 read data |

## Verification
The bench first sends the two threads to different banks, which shows that bank decoding lets them go through in parallel, and then sends them into a single bank, which shows that exactly one thread is granted. Chains of conflicts with a held loser, first in one bank and then in a second bank, separate per-bank round-robin from a shared pointer and from a fixed winner. The bench writes the policy register in the same cycle as a conflict and compares that cycle with the one after it, which shows the one-cycle delay and shows that fixed mode leaves the pointers alone. A write and a read of the same tag in one cycle, followed by a read in the next cycle, separate old data from new.

// File: rtl/rfa_pkg.sv
package rfa_pkg;

  typedef enum logic {
    POL_RR    = 1'b0,
    POL_FIXED = 1'b1
  } pol_e;

  // Grant vector for one bank: bit i = thread i granted.
  function automatic logic [1:0] arb_pick(input logic [1:0] req,
                                          input pol_e      pol,
                                          input logic      prio,
                                          input logic      ptr);
    logic fav;
    if (req == 2'b11) begin
      fav = (pol == POL_FIXED) ? prio : ptr;
      return fav ? 2'b10 : 2'b01;
    end
    return req;
  endfunction

endpackage

// File: rtl/rfa_policy_reg.sv
module rfa_policy_reg
  import rfa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic fixed,
  input  logic prio,
  output pol_e pol_q,
  output logic prio_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q  <= POL_RR;
      prio_q <= 1'b0;
    end else if (we) begin
      pol_q  <= pol_e'(fixed);
      prio_q <= prio;
    end
  end

  // R6
  cfg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (pol_q == pol_e'($past(fixed))) && (prio_q == $past(prio)));

endmodule

// File: rtl/rfa_bank_arb.sv
module rfa_bank_arb
  import rfa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  pol_e       pol,
  input  logic       prio,
  output logic [1:0] gnt,
  output logic       conflict
);

  logic ptr_q;
  logic rr_conflict;

  assign conflict    = (req == 2'b11);
  assign rr_conflict = conflict && (pol == POL_RR);
  assign gnt         = arb_pick(req, pol, prio, ptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n)           ptr_q <= 1'b0;
    else if (rr_conflict) ptr_q <= ~ptr_q;
  end

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> $onehot(gnt));

  // R2
  gnt_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == 2'b00);

  // R3
  fixed_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && pol == POL_FIXED) |-> gnt[prio]);

  // R4
  rr_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_conflict && $past(rst_n) && $past(rr_conflict)) |-> (gnt != $past(gnt)));

endmodule

// File: rtl/rfa_bank_store.sv
module rfa_bank_store #(
  parameter int ROWS   = 16,
  parameter int DATA_W = 32,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (rd_en)  rd_data     <= mem[rd_row];
    if (wr_en)  mem[wr_row] <= wr_data;
  end

endmodule

// File: rtl/rf_bank_arbiter.sv
module rf_bank_arbiter
  import rfa_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TAG_W     = 6,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_fixed,
  input  logic              cfg_prio,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              t0_req,
  input  logic [TAG_W-1:0]  t0_tag,
  input  logic              t1_req,
  input  logic [TAG_W-1:0]  t1_tag,
  output logic              t0_grant,
  output logic              t1_grant,
  output logic              t0_rvalid,
  output logic [DATA_W-1:0] t0_rdata,
  output logic              t1_rvalid,
  output logic [DATA_W-1:0] t1_rdata
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = TAG_W - BANK_W;
  localparam int ROWS   = 1 << ROW_W;

  pol_e pol_q;
  logic prio_q;

  rfa_policy_reg u_pol (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .fixed(cfg_fixed), .prio(cfg_prio),
    .pol_q(pol_q), .prio_q(prio_q)
  );

  logic [BANK_W-1:0] bank0, bank1, wbank;
  logic [ROW_W-1:0]  row0, row1, wrow;

  assign bank0 = t0_tag[BANK_W-1:0];
  assign bank1 = t1_tag[BANK_W-1:0];
  assign wbank = wr_tag[BANK_W-1:0];
  assign row0  = t0_tag[TAG_W-1:BANK_W];
  assign row1  = t1_tag[TAG_W-1:BANK_W];
  assign wrow  = wr_tag[TAG_W-1:BANK_W];

  logic [1:0]        bank_gnt  [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_conf;
  logic [DATA_W-1:0] bank_rd   [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [1:0] req_b;
    assign req_b = {t1_req && (bank1 == BANK_W'(b)), t0_req && (bank0 == BANK_W'(b))};

    rfa_bank_arb u_arb (
      .clk(clk), .rst_n(rst_n), .req(req_b), .pol(pol_q), .prio(prio_q),
      .gnt(bank_gnt[b]), .conflict(bank_conf[b])
    );

    rfa_bank_store #(.ROWS(ROWS), .DATA_W(DATA_W)) u_store (
      .clk(clk),
      .rd_en(|bank_gnt[b]),
      .rd_row(bank_gnt[b][1] ? row1 : row0),
      .wr_en(wr_en && (wbank == BANK_W'(b))),
      .wr_row(wrow),
      .wr_data(wr_data),
      .rd_data(bank_rd[b])
    );
  end

  always_comb begin
    t0_grant = 1'b0;
    t1_grant = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      t0_grant = t0_grant | bank_gnt[b][0];
      t1_grant = t1_grant | bank_gnt[b][1];
    end
  end

  logic [BANK_W-1:0] bank0_q, bank1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t0_rvalid <= 1'b0;
      t1_rvalid <= 1'b0;
      bank0_q   <= '0;
      bank1_q   <= '0;
    end else begin
      t0_rvalid <= t0_grant;
      t1_rvalid <= t1_grant;
      bank0_q   <= bank0;
      bank1_q   <= bank1;
    end
  end

  assign t0_rdata = t0_rvalid ? bank_rd[bank0_q] : '0;
  assign t1_rdata = t1_rvalid ? bank_rd[bank1_q] : '0;

  // R1
  parallel_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_req && t1_req && bank0 != bank1) |-> (t0_grant && t1_grant));

  // R2
  same_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_req && t1_req && bank0 == bank1) |-> (t0_grant ^ t1_grant));

  // R5
  rvalid_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t0_grant |=> t0_rvalid);

  // R5
  rvalid_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t1_grant |=> t1_rvalid);

  // R5
  no_req_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!t0_req |-> !t0_grant) and (!t1_req |-> !t1_grant));

endmodule

// File: tb/tb_rf_bank_arbiter.sv
module tb_rf_bank_arbiter;

  localparam int TAG_W  = 6;
  localparam int DATA_W = 32;
  localparam int NTAGS  = 1 << TAG_W;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_fixed, cfg_prio;
  logic wr_en;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;
  logic t0_req, t1_req;
  logic [TAG_W-1:0] t0_tag, t1_tag;
  logic t0_grant, t1_grant, t0_rvalid, t1_rvalid;
  logic [DATA_W-1:0] t0_rdata, t1_rdata;

  always #5 clk = ~clk;

  rf_bank_arbiter #(.NUM_BANKS(4), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [DATA_W-1:0] model [NTAGS];

  function automatic logic [DATA_W-1:0] pat(input int t);
    return 32'hC0DE_0000 + t * 32'h0101_0003;
  endfunction

  task automatic check(input string req, input string what, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called just after a falling edge: drive, check grants, then check data.
  task automatic cycle(input string req, input logic r0, input int tg0,
                       input logic r1, input int tg1, input logic eg0, input logic eg1);
    logic [DATA_W-1:0] ed0, ed1;
    t0_req = r0; t0_tag = TAG_W'(tg0);
    t1_req = r1; t1_tag = TAG_W'(tg1);
    ed0 = model[tg0]; ed1 = model[tg1];
    #1;
    check(req, "t0_grant", DATA_W'(t0_grant), DATA_W'(eg0));
    check(req, "t1_grant", DATA_W'(t1_grant), DATA_W'(eg1));
    @(posedge clk);
    @(negedge clk);
    check(req, "t0_rvalid", DATA_W'(t0_rvalid), DATA_W'(eg0));
    check(req, "t1_rvalid", DATA_W'(t1_rvalid), DATA_W'(eg1));
    if (eg0) check(req, "t0_rdata", t0_rdata, ed0);
    if (eg1) check(req, "t1_rdata", t1_rdata, ed1);
  endtask

  task automatic idle();
    t0_req = 0; t1_req = 0; cfg_we = 0; wr_en = 0;
  endtask

  task automatic test_reset();
    #1;
    check("R6", "reset t0_grant", DATA_W'(t0_grant), 0);
    check("R5", "reset t0_rvalid", DATA_W'(t0_rvalid), 0);
    check("R5", "reset t1_rvalid", DATA_W'(t1_rvalid), 0);
  endtask

  task automatic preload();
    for (int t = 0; t < NTAGS; t++) begin
      wr_en = 1; wr_tag = TAG_W'(t); wr_data = pat(t);
      @(posedge clk); @(negedge clk);
      model[t] = pat(t);
    end
    wr_en = 0;
  endtask

  task automatic test_parallel();
    cycle("R1", 1, 5, 1, 10, 1, 1);   // banks 1 and 2
    cycle("R1", 1, 0, 1, 7, 1, 1);    // banks 0 and 3
    cycle("R5", 0, 0, 0, 0, 0, 0);    // no requests
    cycle("R5", 1, 33, 0, 0, 1, 0);   // lone request
  endtask

  task automatic test_rr();
    cycle("R4", 1, 4, 1, 8, 1, 0);    // bank 0, pointer at thread 0
    cycle("R4", 1, 12, 1, 8, 0, 1);   // held t1 wins after flip
    cycle("R8", 1, 12, 0, 0, 1, 0);   // held t0 now alone
    cycle("R4", 1, 16, 1, 20, 1, 0);  // pointer back to thread 0
    cycle("R4", 1, 1, 1, 5, 1, 0);    // bank 1 unaffected by bank 0
    cycle("R2", 1, 9, 1, 9, 0, 1);    // identical tag, bank 1 pointer now 1
  endtask

  task automatic test_fixed();
    cfg_we = 1; cfg_fixed = 1; cfg_prio = 1;
    cycle("R6", 1, 2, 1, 6, 1, 0);    // old RR policy, bank 2 pointer 0 -> 1
    cfg_we = 0;
    cycle("R3", 1, 2, 1, 6, 0, 1);
    cycle("R3", 1, 2, 1, 14, 0, 1);
    cycle("R3", 1, 2, 1, 10, 0, 1);
    cycle("R8", 1, 2, 0, 0, 1, 0);
    cfg_we = 1; cfg_fixed = 1; cfg_prio = 0;
    cycle("R6", 1, 3, 1, 7, 0, 1);    // still priority thread 1
    cfg_we = 0;
    cycle("R3", 1, 3, 1, 7, 1, 0);
    cfg_we = 1; cfg_fixed = 0; cfg_prio = 0;
    cycle("R6", 1, 11, 1, 7, 1, 0);   // fixed still active
    cfg_we = 0;
    cycle("R4", 1, 18, 1, 22, 0, 1);  // bank 2 pointer kept 1 through fixed mode
  endtask

  task automatic test_write_read();
    wr_en = 1; wr_tag = TAG_W'(9); wr_data = 32'h1234_5678;
    cycle("R7", 1, 9, 0, 0, 1, 0);    // same-cycle read sees old word
    wr_en = 0;
    model[9] = 32'h1234_5678;
    cycle("R7", 0, 0, 1, 9, 0, 1);    // next cycle sees new word
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    rst_n = 0;
    idle();
    cfg_fixed = 0; cfg_prio = 0; wr_tag = '0; wr_data = '0; t0_tag = '0; t1_tag = '0;
    for (int t = 0; t < NTAGS; t++) model[t] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    test_reset();
    preload();
    test_parallel();
    test_rr();
    test_fixed();
    test_write_read();
    idle();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule